// File: doc/BRIEF.md
# SPI Data Buffer Pair with Side-Effect-Free Debug Read

This block holds the two data words that pass between a host register bus and an SPI shift engine. The host writes a transmit word, which the engine copies into its shift register when a transfer begins. When a transfer ends, the engine hands back the received word. The block latches that word and raises a flag that says unread data is waiting.

The host reads the received word at one of two addresses. A read at the main receive address has side effects: it clears the flag and, in one transfer-initiate mode, asks the engine to begin the next transfer. A read at the debug mirror address returns the same word with no effect on any state, so a debugger can inspect the buffer without disturbing the transfer flow.

Neither data path can be stalled. The transmit word is always presented to the engine, and the engine samples it on its own schedule. A completion pulse from the engine is always accepted, and a new word replaces any word that has not been read. Read data comes back one clock after the read strobe and is marked by a single-cycle valid.

Top module: `spi_data_buffers`

## Requirements
- R1: After reset, `rx_full`, `eng_start` and `host_rvalid` are low and `eng_tx_data` is zero.
- R2: A host write with `host_addr` = 0 loads `host_wdata` into the 32-bit transmit buffer. `eng_tx_data` shows the new word from the next clock, and a later read at address 0 returns it.
- R3: Host writes to addresses 1, 2 and 3 are ignored. The transmit buffer and the receive buffer both keep their values.
- R4: An `eng_done` pulse loads `eng_rx_data` into the 32-bit receive buffer and sets `rx_full` on the next clock.
- R5: Every cycle with `host_rd` high gives exactly one cycle of `host_rvalid` on the next clock, with the selected word on `host_rdata`. A read at address 1 (main receive) returns the receive buffer and clears `rx_full`.
- R6: A read at address 2 (mirror) returns the same word as address 1, leaves `rx_full` unchanged and never raises `eng_start`.
- R7: When `xfer_mode` equals 2'b00 and `eng_busy` is low, a read at address 1 raises `eng_start` for exactly one clock, the clock after the read. In any other mode, while the engine is busy, and for any other address, no start is issued.
- R8: When `eng_done` and a read at address 1 fall in the same cycle, the read returns the word held before that cycle. The new word is loaded and `rx_full` stays set.
- R9: A read at address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_mode | input | 2 | Transfer-initiate mode; 2'b00 lets a main receive read start a transfer |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_addr | input | 2 | 0 transmit, 1 main receive, 2 mirror receive, 3 unused |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with `host_rvalid` |
| host_rvalid | output | 1 | Read data valid, one clock after `host_rd` |
| rx_full | output | 1 | Receive buffer holds unread data |
| eng_busy | input | 1 | Shift engine is mid-transfer |
| eng_start | output | 1 | One-cycle request to begin a transfer |
| eng_tx_data | output | 32 | Transmit buffer contents, copied by the engine at transfer start |
| eng_done | input | 1 | Transfer complete; `eng_rx_data` is valid |
| eng_rx_data | input | 32 | Word assembled by the shift engine |

## Verification
The hardest case to reach is a completion pulse that lands in the same clock as a main receive read. Here the read must return the old word while the flag survives. This case needs the engine-side and host-side strobes to line up exactly. The bench drives that overlap directly in its own step, and it also runs a long stretch of independent random strobes, addresses, modes and busy levels, so the overlap, busy-gated reads and mirror reads of a full buffer all recur. A behavioural model tracks which receive words are known, so reads of the buffer before its first load are never compared.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

  typedef enum logic [1:0] {
    SEL_TX     = 2'd0,
    SEL_RX     = 2'd1,
    SEL_MIRROR = 2'd2,
    SEL_NONE   = 2'd3
  } buf_sel_e;

  localparam logic [1:0] KICK_ON_READ = 2'b00;

  typedef struct packed {
    logic tx_write;
    logic rx_pop;
    logic rx_peek;
    logic any_read;
  } host_op_t;

endpackage

// File: rtl/spi_buf_decode.sv
module spi_buf_decode
  import spi_buf_pkg::*;
(
  input  logic       wr,
  input  logic       rd,
  input  logic [1:0] addr,
  output host_op_t   ops
);

  buf_sel_e sel;

  always_comb begin
    sel          = buf_sel_e'(addr);
    ops.tx_write = wr && (sel == SEL_TX);
    ops.rx_pop   = rd && (sel == SEL_RX);
    ops.rx_peek  = rd && (sel == SEL_MIRROR);
    ops.any_read = rd;
  end

endmodule

// File: rtl/spi_buf_tx.sv
module spi_buf_tx #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] word_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= load_data;
  end

endmodule

// File: rtl/spi_buf_rx.sv
module spi_buf_rx #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] capture_data,
  input  logic              pop,
  output logic [DATA_W-1:0] word_q,
  output logic              full_q
);

  // Data word carries no reset: its contents before the first capture are undefined.
  always_ff @(posedge clk) begin
    if (capture) word_q <= capture_data;
  end

  // Capture outranks pop, so a same-cycle overlap leaves the flag set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       full_q <= 1'b0;
    else if (capture) full_q <= 1'b1;
    else if (pop)     full_q <= 1'b0;
  end

endmodule

// File: rtl/spi_buf_kick.sv
module spi_buf_kick
  import spi_buf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pop,
  input  logic [1:0] mode,
  input  logic       busy,
  output logic       start_q
);

  logic want;

  always_comb want = pop && (mode == KICK_ON_READ) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= want;
  end

endmodule

// File: rtl/spi_data_buffers.sv
module spi_data_buffers
  import spi_buf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        xfer_mode,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              rx_full,
  input  logic              eng_busy,
  output logic              eng_start,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rx_data
);

  host_op_t          ops;
  logic [DATA_W-1:0] tx_word;
  logic [DATA_W-1:0] rx_word;
  logic [DATA_W-1:0] rd_sel;

  spi_buf_decode u_decode (
    .wr   (host_wr),
    .rd   (host_rd),
    .addr (host_addr),
    .ops  (ops)
  );

  spi_buf_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ops.tx_write),
    .load_data (host_wdata),
    .word_q    (tx_word)
  );

  spi_buf_rx #(.DATA_W(DATA_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (eng_done),
    .capture_data (eng_rx_data),
    .pop          (ops.rx_pop),
    .word_q       (rx_word),
    .full_q       (rx_full)
  );

  spi_buf_kick u_kick (
    .clk     (clk),
    .rst_n   (rst_n),
    .pop     (ops.rx_pop),
    .mode    (xfer_mode),
    .busy    (eng_busy),
    .start_q (eng_start)
  );

  // Main and mirror share one source, so they can never disagree.
  always_comb begin
    unique case (buf_sel_e'(host_addr))
      SEL_TX:     rd_sel = tx_word;
      SEL_RX,
      SEL_MIRROR: rd_sel = rx_word;
      default:    rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rvalid <= 1'b0;
    else        host_rvalid <= ops.any_read;
  end

  always_ff @(posedge clk) begin
    if (ops.any_read) host_rdata <= rd_sel;
  end

  assign eng_tx_data = tx_word;

endmodule

// File: rtl/spi_buf_checker.sv
module spi_buf_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        xfer_mode,
  input logic              host_wr,
  input logic              host_rd,
  input logic [1:0]        host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_rvalid,
  input logic              rx_full,
  input logic              eng_busy,
  input logic              eng_start,
  input logic [DATA_W-1:0] eng_tx_data,
  input logic              eng_done,
  input logic [DATA_W-1:0] eng_rx_data
);

  p_tx_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd0) |=> (eng_tx_data == $past(host_wdata)))
    else $error("p_tx_take_r2");

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr != 2'd0) |=> $stable(eng_tx_data))
    else $error("p_tx_hold_r3");

  p_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> rx_full)
    else $error("p_fill_r4");

  p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 2'd1 && !eng_done) |=> !rx_full)
    else $error("p_drain_r5");

  p_rvalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid)
    else $error("p_rvalid_r5");

  p_rquiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !host_rvalid)
    else $error("p_rquiet_r5");

  p_peek_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && host_rd && host_addr == 2'd2) |=> rx_full)
    else $error("p_peek_keep_r6");

  p_peek_nokick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 2'd2) |=> !eng_start)
    else $error("p_peek_nokick_r6");

  p_kick_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(host_rd && host_addr == 2'd1 && xfer_mode == 2'b00 && !eng_busy))
    else $error("p_kick_src_r7");

  p_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && host_rd && host_addr == 2'd1) |=> rx_full)
    else $error("p_overlap_r8");

  p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 2'd3) |=> (host_rdata == '0))
    else $error("p_unused_r9");

endmodule

bind spi_data_buffers spi_buf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_mode   (xfer_mode),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_rdata  (host_rdata),
  .host_rvalid (host_rvalid),
  .rx_full     (rx_full),
  .eng_busy    (eng_busy),
  .eng_start   (eng_start),
  .eng_tx_data (eng_tx_data),
  .eng_done    (eng_done),
  .eng_rx_data (eng_rx_data)
);

// File: tb/spi_data_buffers_bench.sv
`timescale 1ns/1ps
module spi_data_buffers_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  xfer_mode = 2'b00;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        rx_full;
  logic        eng_busy = 1'b0;
  logic        eng_start;
  logic [31:0] eng_tx_data;
  logic        eng_done = 1'b0;
  logic [31:0] eng_rx_data = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  spi_data_buffers u_spi_data_buffers (
    .clk(clk), .rst_n(rst_n), .xfer_mode(xfer_mode),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .rx_full(rx_full), .eng_busy(eng_busy), .eng_start(eng_start),
    .eng_tx_data(eng_tx_data), .eng_done(eng_done), .eng_rx_data(eng_rx_data)
  );

  // Behavioural reference model
  logic [31:0] m_tx, m_rx, m_rdata;
  bit m_full, m_start, m_rvalid, m_rx_known, m_rdata_known;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx = '0; m_full = 0; m_start = 0; m_rvalid = 0;
      m_rx_known = 0; m_rdata_known = 0;
    end else begin
      bit main_rd;
      main_rd  = host_rd && host_addr == 2'd1;
      m_rvalid = host_rd;
      if (host_rd) begin
        case (host_addr)
          2'd0:    begin m_rdata = m_tx; m_rdata_known = 1; end
          2'd3:    begin m_rdata = '0;   m_rdata_known = 1; end
          default: begin m_rdata = m_rx; m_rdata_known = m_rx_known; end
        endcase
      end
      m_start = main_rd && xfer_mode == 2'b00 && !eng_busy;
      if (eng_done) begin
        m_rx = eng_rx_data; m_rx_known = 1; m_full = 1;
      end else if (main_rd) m_full = 0;
      if (host_wr && host_addr == 2'd0) m_tx = host_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4/R5 rx_full", {31'd0, rx_full}, {31'd0, m_full});
      chk("R7 eng_start", {31'd0, eng_start}, {31'd0, m_start});
      chk("R5 host_rvalid", {31'd0, host_rvalid}, {31'd0, m_rvalid});
      chk("R2 eng_tx_data", eng_tx_data, m_tx);
      if (m_rvalid && m_rdata_known) chk("R5 host_rdata", host_rdata, m_rdata);
    end
  end

  // Drive for one clock, then return to idle shortly after the edge
  task automatic step(input bit wr, input bit rd, input logic [1:0] a,
                      input logic [31:0] wd, input logic [1:0] md,
                      input bit bz, input bit dn, input logic [31:0] rxd);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
    xfer_mode = md; eng_busy = bz; eng_done = dn; eng_rx_data = rxd;
    @(posedge clk);
    #2;
    host_wr = 0; host_rd = 0; eng_done = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #35;
    // R1: reset values
    chk("R1 rx_full", {31'd0, rx_full}, 32'd0);
    chk("R1 eng_start", {31'd0, eng_start}, 32'd0);
    chk("R1 host_rvalid", {31'd0, host_rvalid}, 32'd0);
    chk("R1 eng_tx_data", eng_tx_data, 32'd0);
    @(negedge clk); rst_n = 1;

    // R2: write transmit buffer, read it back
    step(1, 0, 2'd0, 32'hA5A5_1234, 2'b00, 0, 0, 0);
    chk("R2 tx after write", eng_tx_data, 32'hA5A5_1234);
    step(0, 1, 2'd0, 0, 2'b00, 0, 0, 0);
    chk("R2 tx readback", host_rdata, 32'hA5A5_1234);

    // R4: completion loads receive buffer
    step(0, 0, 2'd0, 0, 2'b00, 1, 1, 32'hDEAD_BEEF);
    chk("R4 full set", {31'd0, rx_full}, 32'd1);

    // R3: writes to read-only and unused addresses are ignored
    step(1, 0, 2'd1, 32'h1111_1111, 2'b00, 0, 0, 0);
    step(1, 0, 2'd2, 32'h2222_2222, 2'b00, 0, 0, 0);
    step(1, 0, 2'd3, 32'h3333_3333, 2'b00, 0, 0, 0);
    chk("R3 tx unchanged", eng_tx_data, 32'hA5A5_1234);
    step(0, 1, 2'd2, 0, 2'b00, 0, 0, 0);
    chk("R3 rx unchanged", host_rdata, 32'hDEAD_BEEF);

    // R6: mirror read keeps the flag, no start
    chk("R6 full kept", {31'd0, rx_full}, 32'd1);
    chk("R6 no start", {31'd0, eng_start}, 32'd0);

    // R7: main read in mode 00, engine idle -> one start pulse
    step(0, 1, 2'd1, 0, 2'b00, 0, 0, 0);
    chk("R7 start pulse", {31'd0, eng_start}, 32'd1);
    chk("R5 main data", host_rdata, 32'hDEAD_BEEF);
    chk("R5 full cleared", {31'd0, rx_full}, 32'd0);
    @(posedge clk); #2;
    chk("R7 pulse one cycle", {31'd0, eng_start}, 32'd0);

    // R7: other mode, and busy engine -> no start
    step(0, 1, 2'd1, 0, 2'b01, 0, 0, 0);
    chk("R7 mode 01 no start", {31'd0, eng_start}, 32'd0);
    step(0, 1, 2'd1, 0, 2'b00, 1, 0, 0);
    chk("R7 busy no start", {31'd0, eng_start}, 32'd0);

    // R8: completion coincides with main read
    step(0, 0, 2'd0, 0, 2'b00, 1, 1, 32'h0000_00AA);
    step(0, 1, 2'd1, 0, 2'b00, 1, 1, 32'h0000_00BB);
    chk("R8 old data returned", host_rdata, 32'h0000_00AA);
    chk("R8 full stays set", {31'd0, rx_full}, 32'd1);
    step(0, 1, 2'd2, 0, 2'b00, 0, 0, 0);
    chk("R8 new data loaded", host_rdata, 32'h0000_00BB);

    // R9: unused address reads zero
    step(0, 1, 2'd3, 0, 2'b00, 0, 0, 0);
    chk("R9 unused zero", host_rdata, 32'd0);

    // Random traffic, checked each clock by the model
    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 4) == 0, ($urandom % 2) == 0, 2'($urandom), $urandom,
           2'($urandom % 3 == 0 ? 1 : 0), ($urandom % 3) == 0,
           ($urandom % 4) == 0, $urandom);
    end

    repeat (3) @(posedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule